// File: doc/BRIEF.md
# Strong-Bias Update Filter for a Neural Branch Predictor

This block sits beside the weight tables of a neural branch predictor and decides, for every branch, whether the full dot-product result is needed at all. It owns a large table of small signed saturating bias weights. The table is indexed by a hash that folds the branch address and mixes in the global outcome history. When the bias weight for a branch sits at either end of its range, the branch counts as strongly biased. Its direction is then taken from that weight alone. The dot-product sign arrives as an input and is used only for branches that are not strongly biased.

On the training side, the block gates the write enable of the main weight tables. A branch that was filtered at lookup and turned out correct causes no writes anywhere, including the bias table. A filtered branch that was mispredicted falls back to full training and pulls its bias weight one step off saturation. The filtered flag and the table index leave the block with each prediction. The caller carries them with the branch and hands them back at resolution, so the decision at update uses the saturation state seen at lookup time. Two free-running counters report how many updates were suppressed and how many went through.

Top module: `bias_filter_unit`

## Requirements
- R1: After a synchronous active-low reset, every bias weight is 0, and `pred_valid`, `main_we`, `cnt_skip` and `cnt_train` are all 0.
- R2: The table index is the XOR of all IDX_W-bit slices of the branch address (zero-padded at the top) with the global history zero-extended to IDX_W bits. With the defaults this is `pc[9:0] ^ {4'b0,pc[15:10]} ^ {2'b0,ghist}`.
- R3: A bias weight is a 5-bit signed value in -16..15. A training update adds 1 when the branch was taken and subtracts 1 when it was not. The result saturates at 15 and at -16 and never wraps.
- R4: A weight of exactly 15 or exactly -16 marks the lookup as filtered. The prediction is then taken for 15 and not taken for -16, whatever the value of `lk_dot_taken`.
- R5: For an unfiltered lookup, `pred_taken` equals `lk_dot_taken`.
- R6: The lookup outputs appear one clock after `lk_valid` is sampled, and `pred_idx` carries the index of R2. `pred_valid` is 0 in a cycle that follows no lookup.
- R7: An update with `up_filtered`=1 and `up_pred`=`up_taken` is skipped. `main_we` stays 0 in the following cycle and the bias weight does not change.
- R8: An update with `up_filtered`=1 and `up_pred`≠`up_taken` trains. `main_we` is 1 in the following cycle and the bias weight moves one step toward the outcome.
- R9: An unfiltered update trains, as in R8, exactly when `up_train_req` is 1 or `up_pred`≠`up_taken`. Otherwise it writes nothing.
- R10: `cnt_skip` increases by one for each skipped update, and `cnt_train` increases by one for each cycle in which `main_we` is raised.
- R11: A lookup and an update to the same index in the same cycle: the lookup sees the weight as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Branch address of the lookup |
| lk_ghist | input | HIST_W | Global outcome history at lookup |
| lk_dot_taken | input | 1 | Sign of the full dot product (1 = taken) |
| pred_valid | output | 1 | Lookup result valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_filtered | output | 1 | Branch judged strongly biased |
| pred_idx | output | IDX_W | Bias table index to carry with the branch |
| up_valid | input | 1 | Resolved branch update this cycle |
| up_idx | input | IDX_W | Index carried from lookup |
| up_filtered | input | 1 | Filtered flag carried from lookup |
| up_pred | input | 1 | Direction that was predicted |
| up_taken | input | 1 | Resolved direction |
| up_train_req | input | 1 | Main predictor's own training request (low-confidence sum) |
| main_we | output | 1 | Write enable for the main weight tables |
| cnt_skip | output | CNT_W | Count of suppressed updates |
| cnt_train | output | CNT_W | Count of training updates |

## Verification
A lookup and a training update can target the same table entry in one cycle. The bench provokes this by sending both at the entry that sits one step below saturation. It expects the lookup to come back unfiltered, carrying the dot-product sign, and the next lookup of that entry to come back filtered. Filtered lookups and skipped updates also interleave with unfiltered traffic. The scoreboard's own weight model decides every filtered flag, direction, write enable and counter value.

// File: rtl/bf_pkg.sv
// Package for the strong-bias filter: the bias weight type, its
// saturation limits and the saturating step used by training.
// Assumes: bias weights are 5-bit two's complement values.
package bf_pkg;

    localparam int BIAS_W = 5;

    typedef logic signed [BIAS_W-1:0] bias_t;

    localparam bias_t BIAS_MAX = bias_t'((1 << (BIAS_W-1)) - 1);
    localparam bias_t BIAS_MIN = bias_t'(-(1 << (BIAS_W-1)));

    // Moves a weight one step toward the outcome, clamped at the limits.
    function automatic bias_t bias_step(input bias_t w, input logic taken);
        bias_t r;
        if (taken) r = (w == BIAS_MAX) ? w : w + bias_t'(1);
        else       r = (w == BIAS_MIN) ? w : w - bias_t'(1);
        return r;
    endfunction

    // True when a weight sits at either end of its range.
    function automatic logic bias_saturated(input bias_t w);
        return (w == BIAS_MAX) || (w == BIAS_MIN);
    endfunction

endpackage

// File: rtl/bf_bias_table.sv
// Bias weight storage: one combinational read port and one write port
// that applies a saturating step. A read in the same cycle as a write
// to the same entry returns the value before the write.
// Assumes: the write index and direction are stable around the clock edge.
module bf_bias_table
    import bf_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output bias_t            rd_w,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    bias_t mem [DEPTH];

    // Clear all entries on reset, else step the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= bias_step(mem[wr_idx], wr_up);
        end
    end

    // Read the addressed entry without bypass.
    assign rd_w = mem[rd_idx];

    AST_SAT_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] == BIAS_MAX) |=> (mem[$past(wr_idx)] == BIAS_MAX)); // R3
    AST_SAT_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && mem[wr_idx] == BIAS_MIN) |=> (mem[$past(wr_idx)] == BIAS_MIN)); // R3

endmodule

// File: rtl/bf_lookup.sv
// Lookup stage: hashes branch address and history into a table index,
// reads the bias weight, decides whether the branch is strongly biased
// and registers the final prediction with its index.
// Assumes: HIST_W <= IDX_W; the dot-product sign arrives with lk_valid.
module bf_lookup
    import bf_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_ghist,
    input  logic              lk_dot_taken,
    output logic [IDX_W-1:0]  rd_idx,
    input  bias_t             rd_w,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic              pred_filtered,
    output logic [IDX_W-1:0]  pred_idx
);
    localparam int FOLDS = (PC_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W = FOLDS * IDX_W;

    logic [PAD_W-1:0] pc_pad;
    logic [IDX_W-1:0] fold [FOLDS+1];
    logic             sat;
    logic             dir;

    assign pc_pad  = PAD_W'(lk_pc);
    assign fold[0] = IDX_W'(lk_ghist);

    // Chain of XORs, one per address slice.
    for (genvar k = 0; k < FOLDS; k++) begin : g_fold
        assign fold[k+1] = fold[k] ^ pc_pad[k*IDX_W +: IDX_W];
    end

    assign rd_idx = fold[FOLDS];

    // Pick the bias sign for saturated weights, else the dot-product sign.
    always_comb begin
        sat = bias_saturated(rd_w);
        dir = sat ? ~rd_w[BIAS_W-1] : lk_dot_taken;
    end

    // Register the lookup result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid    <= 1'b0;
            pred_taken    <= 1'b0;
            pred_filtered <= 1'b0;
            pred_idx      <= '0;
        end else begin
            pred_valid <= lk_valid;
            if (lk_valid) begin
                pred_taken    <= dir;
                pred_filtered <= sat;
                pred_idx      <= rd_idx;
            end
        end
    end

    AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (pred_valid && pred_idx == $past(rd_idx))); // R6
    AST_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pred_valid); // R6
    AST_UNFILT_FOLLOWS_DOT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !bias_saturated(rd_w)) |=> (pred_taken == $past(lk_dot_taken))); // R5

endmodule

// File: rtl/bf_update_gate.sv
// Update gate: decides per resolved branch whether training happens,
// drives the bias table write, registers the main-table write enable
// and keeps counts of skipped and trained updates.
// Assumes: up_filtered and up_idx are the values returned by lookup.
module bf_update_gate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic             up_filtered,
    input  logic             up_pred,
    input  logic             up_taken,
    input  logic             up_train_req,
    output logic             bias_we,
    output logic             bias_up,
    output logic             main_we,
    output logic [CNT_W-1:0] cnt_skip,
    output logic [CNT_W-1:0] cnt_train
);
    logic mispred;
    logic skip;
    logic train;

    // Classify the update: skipped, training or idle.
    always_comb begin
        mispred = up_pred ^ up_taken;
        skip    = up_valid & up_filtered & ~mispred;
        train   = up_valid & ~skip & (up_train_req | mispred);
    end

    assign bias_we = train;
    assign bias_up = up_taken;

    // Register the main write enable and bump the activity counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_we   <= 1'b0;
            cnt_skip  <= '0;
            cnt_train <= '0;
        end else begin
            main_we <= train;
            if (skip)  cnt_skip  <= cnt_skip + CNT_W'(1);
            if (train) cnt_train <= cnt_train + CNT_W'(1);
        end
    end

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_filtered && up_pred == up_taken) |=> !main_we); // R7
    AST_MISS_TRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_filtered && up_pred != up_taken) |=> main_we); // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid) |=> !main_we); // R9
    AST_SKIP_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (cnt_skip == $past(cnt_skip) || cnt_skip == $past(cnt_skip) + CNT_W'(1))); // R10

endmodule

// File: rtl/bias_filter_unit.sv
// Top of the strong-bias filter: connects lookup, bias table and update
// gate. Lookups and updates may arrive in the same cycle.
// Assumes: the caller returns pred_idx and pred_filtered with each update.
module bias_filter_unit
    import bf_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_ghist,
    input  logic              lk_dot_taken,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic              pred_filtered,
    output logic [IDX_W-1:0]  pred_idx,
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_filtered,
    input  logic              up_pred,
    input  logic              up_taken,
    input  logic              up_train_req,
    output logic              main_we,
    output logic [CNT_W-1:0]  cnt_skip,
    output logic [CNT_W-1:0]  cnt_train
);
    logic [IDX_W-1:0] rd_idx;
    bias_t            rd_w;
    logic             bias_we;
    logic             bias_up;

    bf_lookup #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_lookup (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_pc         (lk_pc),
        .lk_ghist      (lk_ghist),
        .lk_dot_taken  (lk_dot_taken),
        .rd_idx        (rd_idx),
        .rd_w          (rd_w),
        .pred_valid    (pred_valid),
        .pred_taken    (pred_taken),
        .pred_filtered (pred_filtered),
        .pred_idx      (pred_idx)
    );

    bf_bias_table #(.IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_w   (rd_w),
        .wr_en  (bias_we),
        .wr_idx (up_idx),
        .wr_up  (bias_up)
    );

    bf_update_gate #(.CNT_W(CNT_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_valid     (up_valid),
        .up_filtered  (up_filtered),
        .up_pred      (up_pred),
        .up_taken     (up_taken),
        .up_train_req (up_train_req),
        .bias_we      (bias_we),
        .bias_up      (bias_up),
        .main_we      (main_we),
        .cnt_skip     (cnt_skip),
        .cnt_train    (cnt_train)
    );

endmodule

// File: tb/bias_filter_unit_test.sv
// Scoreboard bench: the driver task pushes expected lookup results from
// its own weight model, and a monitor pops and compares them.
module bias_filter_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_pc = '0;
    logic [7:0]  lk_ghist = '0;
    logic        lk_dot_taken = 1'b0;
    logic        pred_valid, pred_taken, pred_filtered;
    logic [9:0]  pred_idx;
    logic        up_valid = 1'b0;
    logic [9:0]  up_idx = '0;
    logic        up_filtered = 1'b0, up_pred = 1'b0, up_taken = 1'b0, up_train_req = 1'b0;
    logic        main_we;
    logic [15:0] cnt_skip, cnt_train;

    int checks = 0;
    int fails  = 0;
    int model [1024];
    int exp_skip = 0, exp_train = 0;
    bit done = 0;

    typedef struct packed {
        logic       taken;
        logic       filt;
        logic [9:0] idx;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    bias_filter_unit uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_ghist(lk_ghist), .lk_dot_taken(lk_dot_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_filtered(pred_filtered), .pred_idx(pred_idx),
        .up_valid(up_valid), .up_idx(up_idx), .up_filtered(up_filtered), .up_pred(up_pred),
        .up_taken(up_taken), .up_train_req(up_train_req),
        .main_we(main_we), .cnt_skip(cnt_skip), .cnt_train(cnt_train)
    );

    function automatic logic [9:0] hidx(input logic [15:0] pc, input logic [7:0] gh);
        return pc[9:0] ^ {4'b0, pc[15:10]} ^ {2'b0, gh};
    endfunction

    function automatic bit is_sat(input int w);
        return (w == 15) || (w == -16);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: one cycle with optional lookup and optional update.
    task automatic step(input bit lv, input logic [15:0] pc, input logic [7:0] gh, input bit dot,
                        input bit uv, input logic [9:0] uidx, input bit uf, input bit up, input bit ut,
                        input bit utr);
        bit skip, train;
        if (lv) begin
            exp_t e;
            int w;
            e.idx   = hidx(pc, gh);
            w       = model[e.idx];
            e.filt  = is_sat(w);
            e.taken = e.filt ? (w == 15) : dot;
            q.push_back(e);
        end
        skip  = uv && uf && (up == ut);
        train = uv && !skip && (utr || up != ut);
        if (train) begin
            if (ut && model[uidx] < 15) model[uidx]++;
            if (!ut && model[uidx] > -16) model[uidx]--;
        end
        if (skip)  exp_skip++;
        if (train) exp_train++;
        lk_valid = lv; lk_pc = pc; lk_ghist = gh; lk_dot_taken = dot;
        up_valid = uv; up_idx = uidx; up_filtered = uf; up_pred = up; up_taken = ut; up_train_req = utr;
        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b0;
        check(main_we == train, skip ? "R7 main_we" : (uf ? "R8 main_we" : "R9 main_we"), main_we, train);
        check(cnt_skip == exp_skip[15:0], "R10 cnt_skip", cnt_skip, exp_skip);
        check(cnt_train == exp_train[15:0], "R10 cnt_train", cnt_train, exp_train);
        if (!lv) check(pred_valid == 1'b0, "R6 idle pred_valid", pred_valid, 0);
    endtask

    task automatic look(input logic [15:0] pc, input logic [7:0] gh, input bit dot);
        step(1, pc, gh, dot, 0, '0, 0, 0, 0, 0);
    endtask

    task automatic train_to(input logic [9:0] idx, input bit dir, input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 1, idx, 0, (i % 2 == 0) ? ~dir : dir, dir, 1);
    endtask

    // Monitor: compare each lookup result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && pred_valid) begin
            if (q.size() == 0) begin
                check(0, "R6 unexpected pred_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(pred_idx == e.idx, "R2 pred_idx", pred_idx, e.idx);
                check(pred_filtered == e.filt, "R4 pred_filtered", pred_filtered, e.filt);
                check(pred_taken == e.taken, e.filt ? "R4 pred_taken" : "R5 pred_taken", pred_taken, e.taken);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_report();
    end

    initial begin
        logic [9:0] ia, ic;
        for (int i = 0; i < 1024; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pred_valid == 0, "R1 pred_valid", pred_valid, 0);
        check(main_we == 0, "R1 main_we", main_we, 0);
        check(cnt_skip == 0 && cnt_train == 0, "R1 counters", cnt_skip + cnt_train, 0);

        ia = hidx(16'h0123, 8'h5A);                 // 0x179
        look(16'h0123, 8'h5A, 1'b0);                // R1 weight 0: unfiltered, R5 dot sign
        look(16'h0123, 8'h5A, 1'b1);                // R5
        train_to(ia, 1'b1, 14);                     // R3 weight 14
        look(16'h0123, 8'h5A, 1'b0);                // still unfiltered at 14
        // R11: lookup and training update hit the same entry together.
        step(1, 16'h0123, 8'h5A, 1'b0, 1, ia, 0, 1, 1, 1);
        look(16'h0123, 8'h5A, 1'b0);                // now 15: R4 filtered taken
        look(16'h0179, 8'h00, 1'b0);                // R2 different pc/history, same entry
        train_to(ia, 1'b1, 3);                      // R3 clamp at 15
        look(16'h0123, 8'h5A, 1'b0);
        // R7: filtered and correct, no writes.
        for (int i = 0; i < 3; i++) step(0, '0, '0, 0, 1, ia, 1, 1, 1, 1);
        look(16'h0123, 8'h5A, 1'b0);                // R7 weight unchanged
        // R9: unfiltered correct without train request writes nothing.
        step(0, '0, '0, 0, 1, 10'h2, 0, 1, 1, 0);
        step(0, '0, '0, 0, 1, 10'h2, 0, 0, 0, 1);   // R9 train request alone trains
        // R8: filtered but wrong -> full training, weight leaves saturation.
        step(0, '0, '0, 0, 1, ia, 1, 1, 0, 0);
        look(16'h0123, 8'h5A, 1'b0);                // unfiltered again, R5
        look(16'h0123, 8'h5A, 1'b1);
        // Negative saturation with a folded high address slice.
        ic = hidx(16'h0400, 8'h00);                 // 0x001
        train_to(ic, 1'b0, 20);                     // R3 clamp at -16
        look(16'h0400, 8'h00, 1'b1);                // R4 filtered not taken
        look(16'h0001, 8'h00, 1'b1);                // R2 fold shares entry
        step(1, 16'h0400, 8'h00, 1'b1, 1, ic, 1, 0, 0, 1); // R7 skip alongside lookup
        step(0, '0, '0, 0, 1, ic, 1, 0, 1, 0);      // R8 wrong: moves to -15
        look(16'h0400, 8'h00, 1'b1);                // R5 unfiltered
        repeat (2) @(negedge clk);
        check(q.size() == 0, "R6 all lookups answered", q.size(), 0);
        finish_report();
    end

endmodule